// File: doc/BRIEF.md
# Temperature Sensor Register Block

A bus-attached control and status unit for an on-chip temperature sensor with its own ADC. Software selects the operating mode, arms a start bit and reads back the latest 12-bit conversion code. After the mode register selects normal operation, the block waits a settling interval. When the settling interval has elapsed and a start is armed, the block issues conversion requests to the ADC at a fixed period with no further software action. It keeps the most recent returned code.

The ADC sits outside the block. The block sends it a one-cycle request strobe and receives a 12-bit code with a valid strobe. Two factory calibration words arrive on static input ports. The block exposes them as read-only registers that carry a validity flag and a 12-bit trim code. The settling and repeat intervals are given in microseconds and converted to clock cycles through a clock-frequency parameter.

Top module: `tsense_regblock`

## Requirements
- R1: The mode register at offset 0x00 holds two bits: bit 0 enables the sensor and drives `sensorEn`, and bit 1 enables the ADC and drives `adcEn`. Both bits read back, and bits 31:2 read as zero. Normal mode means both bits are 1.
- R2: A write to bit 0 of the start register (offset 0x04) is accepted only while the mode register holds normal mode. At any other time the write is ignored and the register reads 0.
- R3: Settling takes SETTLE_US*CLK_MHZ cycles after the mode register becomes normal. Status bit 0 (offset 0x10) rises in the cycle after both of these are true: settling is complete and the start bit is set. A start armed during settling is therefore held until settling ends.
- R4: While status bit 0 is 1, `convReq` pulses for one cycle in the first running cycle and then every PERIOD_US*CLK_MHZ cycles. It is never high at other times.
- R5: The result register (offset 0x0C) takes `adcCode` into bits 11:0 on each `adcValid` while running, and bits 31:12 read zero. An `adcValid` while not running leaves the register unchanged.
- R6: When the mode register leaves normal mode, the start bit, the settling progress and (one cycle later) status bit 0 are all cleared, and conversions stop.
- R7: Writing 0 to the start bit while running clears status bit 0 on the next cycle and stops `convReq`.
- R8: The trim registers at 0x18 and 0x1C read bit 31 and bits 11:0 of `trim0`/`trim1`, with all other bits zero. Writes to them have no effect.
- R9: Reads from unmapped offsets return zero.
- R10: After reset every register reads zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (same cycle) |
| adcCode | input | 12 | Conversion code from the ADC |
| adcValid | input | 1 | adcCode is valid this cycle |
| trim0 | input | 32 | Calibration word 0 |
| trim1 | input | 32 | Calibration word 1 |
| sensorEn | output | 1 | Sensor enable |
| adcEn | output | 1 | ADC enable |
| convReq | output | 1 | One-cycle conversion request |

## Verification
The bench builds the block with CLK_MHZ=2. That makes settling 120 cycles and the repeat period 40 cycles. With these values, a start armed early, several complete repeat periods, stopping through either register, and restarting without a second settle all fit within a few hundred cycles. A behavioural model is compared against every output and the addressed read value on every clock. A stand-in ADC answers each request three cycles later. Stray valid strobes are injected while the block is stopped and while it is running.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
  localparam logic [7:0] OFS_MODE   = 8'h00;
  localparam logic [7:0] OFS_START  = 8'h04;
  localparam logic [7:0] OFS_RESULT = 8'h0C;
  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_TRIM0  = 8'h18;
  localparam logic [7:0] OFS_TRIM1  = 8'h1C;

  typedef struct packed {
    logic [1:0] mode;
    logic       startBit;
    logic       running;
    logic       capture;
  } ctrlLink_t;
endpackage

// File: rtl/tsense_ctrl.sv
module tsense_ctrl
  import tsense_pkg::*;
#(
  parameter int SETTLE_CYC = 6000,
  parameter int PERIOD_CYC = 2000,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        wrBits,
  output ctrlLink_t         link,
  output logic              convReq
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int PW = $clog2(PERIOD_CYC + 1);

  logic [1:0]    modeQ;
  logic          startQ, settledQ, runQ;
  logic [SW-1:0] settleCnt;
  logic [PW-1:0] periodCnt;
  logic          normal, wrMode, wrStart;

  assign normal  = &modeQ;
  assign wrMode  = busSel && busWrite && (busAddr == ADDR_W'(OFS_MODE));
  assign wrStart = busSel && busWrite && (busAddr == ADDR_W'(OFS_START));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ     <= '0;
      startQ    <= 1'b0;
      settledQ  <= 1'b0;
      runQ      <= 1'b0;
      settleCnt <= '0;
      periodCnt <= '0;
    end else begin
      if (wrMode) modeQ <= wrBits;

      if (!normal)      startQ <= 1'b0;
      else if (wrStart) startQ <= wrBits[0];

      if (!normal) begin
        settleCnt <= '0;
        settledQ  <= 1'b0;
      end else if (!settledQ) begin
        if (settleCnt == SW'(SETTLE_CYC - 1)) settledQ  <= 1'b1;
        else                                  settleCnt <= settleCnt + 1'b1;
      end

      runQ <= normal && settledQ && startQ;

      if (!runQ || periodCnt == PW'(PERIOD_CYC - 1)) periodCnt <= '0;
      else                                           periodCnt <= periodCnt + 1'b1;
    end
  end

  assign convReq       = runQ && (periodCnt == '0);
  assign link.mode     = modeQ;
  assign link.startBit = startQ;
  assign link.running  = runQ;
  assign link.capture  = runQ;
endmodule

// File: rtl/tsense_dp.sv
module tsense_dp
  import tsense_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlLink_t         link,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CODE_W-1:0] adcCode,
  input  logic              adcValid,
  input  logic [31:0]       trim0,
  input  logic [31:0]       trim1,
  output logic [31:0]       busRdata,
  output logic [CODE_W-1:0] resultCode
);
  localparam int PAD = 31 - CODE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         resultCode <= '0;
    else if (link.capture && adcValid)  resultCode <= adcCode;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(OFS_MODE):   busRdata = {30'b0, link.mode};
      ADDR_W'(OFS_START):  busRdata = {31'b0, link.startBit};
      ADDR_W'(OFS_RESULT): busRdata = {{(32-CODE_W){1'b0}}, resultCode};
      ADDR_W'(OFS_STATUS): busRdata = {31'b0, link.running};
      ADDR_W'(OFS_TRIM0):  busRdata = {trim0[31], {PAD{1'b0}}, trim0[CODE_W-1:0]};
      ADDR_W'(OFS_TRIM1):  busRdata = {trim1[31], {PAD{1'b0}}, trim1[CODE_W-1:0]};
      default:             busRdata = '0;
    endcase
  end
endmodule

// File: rtl/tsense_regblock.sv
module tsense_regblock
  import tsense_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int SETTLE_US = 60,
  parameter int PERIOD_US = 20,
  parameter int ADDR_W    = 8,
  parameter int CODE_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [CODE_W-1:0] adcCode,
  input  logic              adcValid,
  input  logic [31:0]       trim0,
  input  logic [31:0]       trim1,
  output logic              sensorEn,
  output logic              adcEn,
  output logic              convReq
);
  localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
  localparam int PERIOD_CYC = PERIOD_US * CLK_MHZ;

  ctrlLink_t         link;
  logic              running;
  logic [CODE_W-1:0] resultCode;

  tsense_ctrl #(.SETTLE_CYC(SETTLE_CYC), .PERIOD_CYC(PERIOD_CYC), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .wrBits(busWdata[1:0]), .link(link), .convReq(convReq)
  );

  tsense_dp #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .link(link), .busAddr(busAddr),
    .adcCode(adcCode), .adcValid(adcValid), .trim0(trim0), .trim1(trim1),
    .busRdata(busRdata), .resultCode(resultCode)
  );

  assign sensorEn = link.mode[0];
  assign adcEn    = link.mode[1];
  assign running  = link.running;
endmodule

// File: rtl/tsense_chk.sv
module tsense_chk #(
  parameter int SETTLE_CYC = 6000,
  parameter int CODE_W     = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sensorEn,
  input logic              adcEn,
  input logic              convReq,
  input logic              running,
  input logic              adcValid,
  input logic [CODE_W-1:0] resultCode
);
  localparam int CW = $clog2(SETTLE_CYC + 2) + 1;
  logic [CW-1:0] normCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   normCnt <= '0;
    else if (!(sensorEn && adcEn)) normCnt <= '0;
    else if (normCnt <= CW'(SETTLE_CYC)) normCnt <= normCnt + 1'b1;
  end

  // R4
  req_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    convReq |-> running);
  // R4
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    convReq |=> !convReq);
  // R4
  first_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> convReq);
  // R3
  settle_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (normCnt >= CW'(SETTLE_CYC)));
  // R6
  mode_drop_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sensorEn && adcEn) |=> !running);
  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(adcValid && running) |=> $stable(resultCode));
endmodule

bind tsense_regblock tsense_chk #(.SETTLE_CYC(SETTLE_CYC), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sensorEn(sensorEn), .adcEn(adcEn), .convReq(convReq),
  .running(running), .adcValid(adcValid), .resultCode(resultCode)
);

// File: tb/test_tsense_regblock.sv
module test_tsense_regblock;
  localparam int T       = 10;
  localparam int MHZ     = 2;
  localparam int SETTLE  = 60 * MHZ;
  localparam int PERIOD  = 20 * MHZ;

  logic        clk = 0, rst_n = 0;
  logic        busSel = 0, busWrite = 0;
  logic [7:0]  busAddr = 0;
  logic [31:0] busWdata = 0, busRdata;
  logic [11:0] adcCode;
  logic        adcValid;
  logic [31:0] trim0 = 32'hFFF0_5C4C, trim1 = 32'h0ABC_D1F7;
  logic        sensorEn, adcEn, convReq;

  logic        stubValid = 0, strayValid = 0;
  logic [11:0] stubCode = 0, strayCode = 0;
  assign adcValid = stubValid | strayValid;
  assign adcCode  = strayValid ? strayCode : stubCode;

  integer vecs = 0, fails = 0;
  bit     done = 0;

  tsense_regblock #(.CLK_MHZ(MHZ)) i_tsense_regblock (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .adcCode(adcCode), .adcValid(adcValid),
    .trim0(trim0), .trim1(trim1), .sensorEn(sensorEn), .adcEn(adcEn), .convReq(convReq)
  );

  always #(T/2) clk = ~clk;

  // behavioural reference
  integer mMode = 0, mStart = 0, mSetCnt = 0, mSettled = 0, mRun = 0, mPcnt = 0, mResult = 0;
  always @(posedge clk) begin
    integer nMode, nStart, nSetCnt, nSettled, nRun, nPcnt, nResult;
    bit wr;
    if (!rst_n) begin
      mMode = 0; mStart = 0; mSetCnt = 0; mSettled = 0; mRun = 0; mPcnt = 0; mResult = 0;
    end else begin
      wr = busSel && busWrite;
      nMode = (wr && busAddr == 8'h00) ? int'(busWdata[1:0]) : mMode;
      if (mMode != 3) nStart = 0;
      else if (wr && busAddr == 8'h04) nStart = int'(busWdata[0]);
      else nStart = mStart;
      nSetCnt = mSetCnt; nSettled = mSettled;
      if (mMode != 3) begin nSetCnt = 0; nSettled = 0; end
      else if (mSettled == 0) begin
        if (mSetCnt == SETTLE - 1) nSettled = 1; else nSetCnt = mSetCnt + 1;
      end
      nRun  = (mMode == 3 && mSettled == 1 && mStart == 1) ? 1 : 0;
      nPcnt = (mRun == 0 || mPcnt == PERIOD - 1) ? 0 : mPcnt + 1;
      nResult = (adcValid && mRun == 1) ? int'(adcCode) : mResult;
      mMode = nMode; mStart = nStart; mSetCnt = nSetCnt; mSettled = nSettled;
      mRun = nRun; mPcnt = nPcnt; mResult = nResult;
    end
  end

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h00: return 32'(mMode);
      8'h04: return 32'(mStart);
      8'h0C: return 32'(mResult);
      8'h10: return 32'(mRun);
      8'h18: return {trim0[31], 19'b0, trim0[11:0]};
      8'h1C: return {trim1[31], 19'b0, trim1[11:0]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(input logic [7:0] a);
    if (!rst_n) return "R10";
    case (a)
      8'h00: return "R1";
      8'h04: return "R2";
      8'h0C: return "R5";
      8'h10: return "R3 R6 R7";
      8'h18, 8'h1C: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // compare every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(T/4);
    if (!done) begin
      check({tagOf(busAddr), " rdata"}, busRdata, expRead(busAddr));
      check("R1 sensorEn", 32'(sensorEn), 32'(mMode & 1));
      check("R1 adcEn", 32'(adcEn), 32'((mMode >> 1) & 1));
      check("R4 convReq", 32'(convReq), 32'(mRun == 1 && mPcnt == 0));
    end
  end

  // stand-in ADC: answers three cycles after a request
  integer dly = -1;
  always @(negedge clk) begin
    stubValid = 0;
    if (convReq) dly = 3;
    else if (dly > 0) dly = dly - 1;
    if (dly == 0) begin
      stubValid = 1;
      stubCode  = stubCode + 12'h2A7;
      dly = -1;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic look(input logic [7:0] a, input int n);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    idle(n);
    busSel = 0;
  endtask

  task automatic stray(input logic [11:0] c);
    @(negedge clk);
    strayValid = 1; strayCode = c;
    @(negedge clk);
    strayValid = 0;
  endtask

  initial begin
    #(T * 100000);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    // R10 reset state
    idle(3);
    foreach (trim0[i]) if (i < 6) look(8'(i * 4), 1);
    rst_n = 1;
    // R8 R9 reads and ignored writes
    look(8'h18, 2); look(8'h1C, 2); look(8'h08, 1); look(8'h14, 1); look(8'h20, 1);
    wr(8'h18, 32'h0); wr(8'h0C, 32'hFFF); look(8'h18, 1); look(8'h0C, 1);
    // R2 start ignored outside normal mode; R5 stray valid ignored when stopped
    wr(8'h04, 1); look(8'h04, 2);
    wr(8'h00, 32'hFFFF_FFFD); look(8'h00, 2);   // R1 only bit 0 kept
    wr(8'h04, 1); look(8'h04, 2);
    stray(12'hABC); look(8'h0C, 2);
    // R3 start armed early waits for settling
    wr(8'h00, 3); wr(8'h04, 1);
    look(8'h10, SETTLE + 10);
    // R4 periodic requests, R5 results
    look(8'h0C, 3 * PERIOD + 7);
    stray(12'h5A5); look(8'h0C, 3);
    // R7 start cleared stops conversions
    wr(8'h04, 0); look(8'h10, PERIOD + 5);
    stray(12'h111); look(8'h0C, 2);
    // restart without re-settling
    wr(8'h04, 1); look(8'h10, 2 * PERIOD);
    // R6 leaving normal mode stops everything
    wr(8'h00, 2); look(8'h10, 4); look(8'h04, 2); look(8'h0C, PERIOD);
    // R6 re-entering normal mode needs a fresh settle
    wr(8'h00, 3); wr(8'h04, 1); look(8'h10, SETTLE / 2);
    wr(8'h00, 0); look(8'h10, SETTLE + 5);
    idle(5);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule